// File: doc/BRIEF.md
# Fuse Shadow-Read Controller

This block fronts a one-time-programmable fuse array with a small word-addressed register bus. Software sees one control word and a bank of shadow words. Setting the bank-open bit in the control word starts a fixed-length fetch. During the fetch the block reports busy and copies the fuse contents into the shadow words, one word per clock. When the fetch ends, the shadow words can be read. Clearing the bank-open bit closes the banks, and shadow reads then return zero again.

The control word can be written through four byte offsets. Each offset applies the written mask in a different way: plain write, OR, AND-NOT or XOR. The fuse contents come from a constant vector parameter. A second parameter forces every fetch to end with a sticky error instead of loaded data, so that software error paths can be exercised.

Top module: `otp_shadow_top`

## Requirements
- R1: After a synchronous active-high reset, the control word reads 0x0000_0000 and every shadow word reads zero.
- R2: The control word reads at any of byte offsets 0x0, 0x4, 0x8 and 0xC. Bit 12 is bank-open, bit 9 is error, bit 8 is busy, and all other bits read zero. A plain write at 0x0 assigns bank-open and error from the written data. A written busy bit has no effect.
- R3: A write at offset 0x4 ORs the written bits into the control word.
- R4: A write at offset 0x8 clears the control bits whose mask bits are 1.
- R5: A write at offset 0xC inverts the control bits whose mask bits are 1.
- R6: When bank-open goes from 0 to 1 and neither busy nor error is set, busy reads 1 for exactly BUSY_CYCLES (default 32) cycles. It starts in the cycle after the write.
- R7: After the fetch, shadow word i reads at byte offset 0x20 + 0x10*i and returns word i of the fuse vector, where word i is bits [32*i+31 : 32*i].
- R8: A shadow read returns zero while busy is set, and also after bank-open has been cleared.
- R9: Error is sticky. Software can only clear it, through any write whose alias result for bit 9 is 0. A write whose result would set it has no effect.
- R10: A request to set bank-open while error is set is ignored, and bank-open stays 0. Any change to bank-open requested while busy is set is also ignored.
- R11: With ERR_INJECT set, a fetch ends by setting error. The shadow words then stay unloaded and read zero.
- R12: A read returns zero when the read enable is low. Reads at unmapped offsets return zero: these are offsets 0x10 to 0x1F, misaligned shadow offsets, and offsets past the last word. Writes to shadow offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write strobe for this cycle |
| rdEn | input | 1 | Read strobe for this cycle |
| addr | input | ADDR_W | Byte offset of the access |
| wrData | input | DATA_W | Write data or alias mask |
| rdData | output | DATA_W | Combinational read data, zero when rdEn is low |

## Verification
On every cycle the assertions check these invariants: busy implies bank-open, each busy window lasts exactly BUSY_CYCLES, error holds across cycles without a write, no bank opens while error is set, shadow reads during busy return zero, and the bus is quiet with no read. The alias arithmetic, the fuse word placement and the effect of closing the banks need known data. The error-injected outcome also needs known data. The bench's scenarios show these by comparing every read against a behavioural model, and by comparing a second, error-injecting instance against fixed expected words.

// File: rtl/otp_shadow_pkg.sv
package otp_shadow_pkg;

  localparam int OFF_SHADOW    = 'h20;
  localparam int BIT_BUSY      = 8;
  localparam int BIT_ERR       = 9;
  localparam int BIT_OPEN      = 12;
  localparam int IDX_W         = 8;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TOG   = 2'd3
  } aliasOp_e;

  // strobes from the sequencer to the shadow storage
  typedef struct packed {
    logic             clearAll;
    logic             loadEn;
    logic [IDX_W-1:0] loadIdx;
    logic             shadowValid;
  } shadowStrb_t;

  function automatic logic applyAlias(aliasOp_e op, logic cur, logic mask);
    case (op)
      OP_SET:  return cur | mask;
      OP_CLR:  return cur & ~mask;
      OP_TOG:  return cur ^ mask;
      default: return mask;
    endcase
  endfunction

endpackage

// File: rtl/otp_shadow_ctl.sv
module otp_shadow_ctl
  import otp_shadow_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int NUM_WORDS   = 32,
  parameter int BUSY_CYCLES = 32,
  parameter int ERR_INJECT  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] ctrlWord,
  output shadowStrb_t       strb,
  output logic              busy,
  output logic              open,
  output logic              err
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(BUSY_CYCLES - 1);
  localparam logic [CNT_W-1:0] LOAD_LIM  = CNT_W'(NUM_WORDS);

  logic             openQ, errQ, busyQ, loadedQ;
  logic             openN, errN, busyN, loadedN;
  logic [CNT_W-1:0] cntQ, cntN;
  logic             isCtrl, wrCtl, errRes, openRes;
  aliasOp_e         op;
  shadowStrb_t      strbN;
  logic             unusedData;

  assign unusedData = ^wrData;

  assign isCtrl  = (addr[ADDR_W-1:4] == '0) && (addr[1:0] == 2'b00);
  assign op      = aliasOp_e'(addr[3:2]);
  assign wrCtl   = wrEn && isCtrl;
  assign errRes  = applyAlias(op, errQ, wrData[BIT_ERR]);
  assign openRes = applyAlias(op, openQ, wrData[BIT_OPEN]);

  always_comb begin
    openN   = openQ;
    errN    = errQ;
    busyN   = busyQ;
    loadedN = loadedQ;
    cntN    = cntQ;
    strbN   = '0;

    if (wrCtl) begin
      errN = errQ & errRes;
      if (!busyQ) begin
        if (openRes && !openQ && !errQ) begin
          openN          = 1'b1;
          busyN          = 1'b1;
          cntN           = '0;
          loadedN        = 1'b0;
          strbN.clearAll = 1'b1;
        end else if (!openRes && openQ) begin
          openN   = 1'b0;
          loadedN = 1'b0;
        end
      end
    end

    if (busyQ) begin
      if (ERR_INJECT == 0 && cntQ < LOAD_LIM) begin
        strbN.loadEn  = 1'b1;
        strbN.loadIdx = IDX_W'(cntQ);
      end
      if (cntQ == LAST_CNT) begin
        busyN = 1'b0;
        cntN  = '0;
        if (ERR_INJECT != 0) errN = 1'b1;
        else                 loadedN = 1'b1;
      end else begin
        cntN = cntQ + 1'b1;
      end
    end

    strbN.shadowValid = openQ && loadedQ && !busyQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      openQ   <= 1'b0;
      errQ    <= 1'b0;
      busyQ   <= 1'b0;
      loadedQ <= 1'b0;
      cntQ    <= '0;
    end else begin
      openQ   <= openN;
      errQ    <= errN;
      busyQ   <= busyN;
      loadedQ <= loadedN;
      cntQ    <= cntN;
    end
  end

  always_comb begin
    ctrlWord           = '0;
    ctrlWord[BIT_OPEN] = openQ;
    ctrlWord[BIT_ERR]  = errQ;
    ctrlWord[BIT_BUSY] = busyQ;
  end

  assign strb = strbN;
  assign busy = busyQ;
  assign open = openQ;
  assign err  = errQ;

endmodule

// File: rtl/otp_shadow_dat.sv
module otp_shadow_dat
  import otp_shadow_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 32,
  parameter logic [NUM_WORDS*DATA_W-1:0] FUSE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  shadowStrb_t       strb,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] ctrlWord,
  output logic [DATA_W-1:0] rdData
);

  localparam int WIDX_W = ADDR_W - 4;

  logic [DATA_W-1:0] shadowQ [NUM_WORDS];
  logic [ADDR_W-1:0] offs;
  logic [WIDX_W-1:0] wordIdx;
  logic              isCtrl, isShadow;
  logic [DATA_W-1:0] shadowSel;

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst || strb.clearAll)
        shadowQ[i] <= '0;
      else if (strb.loadEn && strb.loadIdx == IDX_W'(i))
        shadowQ[i] <= FUSE[i*DATA_W +: DATA_W];
    end
  end

  assign offs     = addr - ADDR_W'(OFF_SHADOW);
  assign wordIdx  = offs[ADDR_W-1:4];
  assign isCtrl   = (addr[ADDR_W-1:4] == '0) && (addr[1:0] == 2'b00);
  assign isShadow = (addr >= ADDR_W'(OFF_SHADOW)) && (offs[3:0] == 4'h0) &&
                    (int'(wordIdx) < NUM_WORDS);

  always_comb begin
    shadowSel = '0;
    for (int i = 0; i < NUM_WORDS; i++)
      if (wordIdx == WIDX_W'(i)) shadowSel = shadowQ[i];
  end

  always_comb begin
    if (!rdEn)                           rdData = '0;
    else if (isCtrl)                     rdData = ctrlWord;
    else if (isShadow && strb.shadowValid) rdData = shadowSel;
    else                                 rdData = '0;
  end

endmodule

// File: rtl/otp_shadow_top.sv
module otp_shadow_top
  import otp_shadow_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int NUM_WORDS   = 32,
  parameter int BUSY_CYCLES = 32,
  parameter int ERR_INJECT  = 0,
  parameter logic [NUM_WORDS*DATA_W-1:0] FUSE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  shadowStrb_t       strb;
  logic [DATA_W-1:0] ctrlWord;
  logic              busyFlag, openFlag, errFlag;

  otp_shadow_ctl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS),
    .BUSY_CYCLES(BUSY_CYCLES), .ERR_INJECT(ERR_INJECT)
  ) u_ctl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .ctrlWord(ctrlWord), .strb(strb),
    .busy(busyFlag), .open(openFlag), .err(errFlag)
  );

  otp_shadow_dat #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .FUSE(FUSE)
  ) u_dat (
    .clk(clk), .rst(rst), .strb(strb), .rdEn(rdEn), .addr(addr),
    .ctrlWord(ctrlWord), .rdData(rdData)
  );

endmodule

// File: rtl/otp_shadow_chk.sv
module otp_shadow_chk #(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int BUSY_CYCLES = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdData,
  input logic              busy,
  input logic              open,
  input logic              err
);

  logic [15:0] busyLen;

  always_ff @(posedge clk) begin
    if (rst)       busyLen <= '0;
    else if (busy) busyLen <= busyLen + 16'd1;
    else           busyLen <= '0;
  end

  a_r6_busy_needs_open: assert property (@(posedge clk) disable iff (rst)
    busy |-> open);

  a_r6_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> busyLen == 16'(BUSY_CYCLES));

  a_r8_quiet_while_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && rdEn && addr >= ADDR_W'('h20)) |-> rdData == '0);

  a_r12_idle_bus: assert property (@(posedge clk) disable iff (rst)
    !rdEn |-> rdData == '0);

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (err && !wrEn) |=> err);

  a_r10_no_open_on_err: assert property (@(posedge clk) disable iff (rst)
    (!open && err) |=> !open);

endmodule

bind otp_shadow_top otp_shadow_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .rdData(rdData), .busy(busyFlag), .open(openFlag), .err(errFlag)
);

// File: tb/otp_shadow_top_tb.sv
module otp_shadow_top_tb;

  localparam int NW = 32;
  localparam int BC = 32;

  function automatic logic [NW*32-1:0] makeFuse();
    logic [NW*32-1:0] v;
    for (int i = 0; i < NW; i++)
      v[i*32 +: 32] = {8'(i) ^ 8'h5A, 8'(i * 3), 8'hC0 | 8'(i), ~8'(i)};
    return v;
  endfunction

  localparam logic [NW*32-1:0] FUSE_IMG = makeFuse();

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData, rdDataErr;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  // behavioural reference state for u_dut
  bit modOpen = 0, modErr = 0, modLoaded = 0;
  int modBusy = 0;

  always #10 clk = ~clk;

  otp_shadow_top #(.NUM_WORDS(NW), .BUSY_CYCLES(BC), .ERR_INJECT(0), .FUSE(FUSE_IMG)) u_dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData));

  otp_shadow_top #(.NUM_WORDS(NW), .BUSY_CYCLES(BC), .ERR_INJECT(1), .FUSE(FUSE_IMG)) u_dutErr (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdDataErr));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s addr=0x%03h actual=0x%08h expected=0x%08h", tag, addr, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(logic rd, logic [11:0] a);
    int idx;
    if (!rd) return '0;
    if (a < 12'h10 && a[1:0] == 2'b00)
      return (32'(modOpen) << 12) | (32'(modErr) << 9) | (32'(modBusy > 0) << 8);
    if (a >= 12'h20 && a[3:0] == 4'h0) begin
      idx = (int'(a) - 'h20) / 16;
      if (idx < NW && modOpen && modLoaded && modBusy == 0)
        return FUSE_IMG[idx*32 +: 32];
    end
    return '0;
  endfunction

  function automatic bit aliasRes(int op, bit cur, bit m);
    case (op)
      1: return cur | m;
      2: return cur & !m;
      3: return cur ^ m;
      default: return m;
    endcase
  endfunction

  task automatic modelStep(logic wr, logic [11:0] a, logic [31:0] d);
    bit busyNow = (modBusy > 0);
    bit oldErr = modErr;
    if (wr && a < 12'h10 && a[1:0] == 2'b00) begin
      bit eR = aliasRes(int'(a[3:2]), modErr, d[9]);
      bit oR = aliasRes(int'(a[3:2]), modOpen, d[12]);
      modErr = modErr & eR;
      if (!busyNow) begin
        if (oR && !modOpen && !oldErr) begin
          modOpen = 1; modLoaded = 0; modBusy = BC + 1;
        end else if (!oR && modOpen) begin
          modOpen = 0; modLoaded = 0;
        end
      end
    end
    if (modBusy > 0) begin
      modBusy--;
      if (modBusy == 0) modLoaded = 1;
    end
  endtask

  task automatic doOp(logic wr, logic rd, logic [11:0] a, logic [31:0] d, string tag,
                      bit chkE = 0, logic [31:0] expE = '0);
    @(negedge clk);
    wrEn = wr; rdEn = rd; addr = a; wrData = d;
    #1;
    check(tag, rdData, modelRead(rd, a));
    if (chkE) check({tag, " (err instance)"}, rdDataErr, expE);
    @(posedge clk);
    modelStep(wr, a, d);
  endtask

  task automatic rdOp(logic [11:0] a, string tag);
    doOp(0, 1, a, '0, tag);
  endtask

  task automatic wrOp(logic [11:0] a, logic [31:0] d, string tag);
    doOp(1, 0, a, d, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    rdOp(12'h000, "R1"); rdOp(12'h020, "R1"); rdOp(12'h210, "R1");
    doOp(0, 0, 12'h000, '0, "R12");

    wrOp(12'h000, 32'h0000_0101, "R2");
    rdOp(12'h000, "R2");
    rdOp(12'h014, "R12"); rdOp(12'h024, "R12"); rdOp(12'h220, "R12"); rdOp(12'h800, "R12");

    wrOp(12'h004, 32'h0000_0200, "R9");
    rdOp(12'h000, "R9");

    // open both instances; the error instance must end in error
    wrOp(12'h004, 32'h0000_1000, "R3");
    rdOp(12'h008, "R6");
    for (int k = 0; k < 10; k++) rdOp(12'h020 + 12'(k * 16), "R8");
    wrOp(12'h008, 32'h0000_1000, "R10");
    for (int k = 0; k < 25; k++) rdOp(12'h000, "R6");
    doOp(0, 1, 12'h000, '0, "R11", 1, 32'h0000_1200);
    doOp(0, 1, 12'h020, '0, "R11", 1, 32'h0000_0000);

    for (int i = 0; i < NW; i++) rdOp(12'h020 + 12'(i * 16), "R7");
    doOp(0, 1, 12'h070, '0, "R7", 0, '0);
    check("R7 word 5 direct", rdData, 32'h5F0F_C5FA);

    wrOp(12'h030, 32'hDEAD_BEEF, "R12");
    rdOp(12'h030, "R12");

    wrOp(12'h000, 32'h0000_1200, "R2");
    rdOp(12'h000, "R2"); rdOp(12'h040, "R2");

    wrOp(12'h008, 32'h0000_1000, "R4");
    rdOp(12'h000, "R4"); rdOp(12'h020, "R8");

    wrOp(12'h00C, 32'h0000_1000, "R5");
    for (int k = 0; k < BC + 2; k++) rdOp(12'h000, "R5");
    rdOp(12'h050, "R5");
    wrOp(12'h00C, 32'h0000_1000, "R5");
    rdOp(12'h000, "R5"); rdOp(12'h050, "R8");

    doOp(0, 1, 12'h000, '0, "R10", 1, 32'h0000_0200);
    wrOp(12'h004, 32'h0000_1000, "R10");
    doOp(0, 1, 12'h000, '0, "R10", 1, 32'h0000_0200);
    wrOp(12'h008, 32'h0000_0200, "R9");
    doOp(0, 1, 12'h000, '0, "R9", 1, 32'h0000_0000);
    for (int k = 0; k < BC + 2; k++) rdOp(12'h000, "R6");
    wrOp(12'h00C, 32'h0000_0200, "R9");
    rdOp(12'h000, "R9"); rdOp(12'h210, "R7");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule